// File: doc/BRIEF.md
# Modulo Up/Down Counter

A clocked binary counter whose width is a parameter. It can wrap at a chosen modulus or at its natural power of two. The counting direction is set at build time: it either always counts up, always counts down, or follows a direction input while the block runs. Three synchronous commands can override counting: clear to zero, jump to a constant preset, and load an arbitrary value from the data input.

Two enables work at different levels. The clock enable freezes every register action, including the commands. The count enable only stops the stepping, so the commands still work while it is low. The output is the raw count vector with no number formatting. The block is meant for sequencing, address generation and rate division inside a larger datapath.

Top module: `modcount_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes zero on that edge.
- R2: With `clk_en` high, `clr_en` sets the count to zero on the next edge, whatever the other command inputs are.
- R3: With `clk_en` high and `clr_en` low, `set_en` loads the constant `SET_VALUE` and overrides `load_en` and counting, provided the width is at most 31 bits.
- R4: With `clk_en` high and no clear or set, `load_en` loads `load_val` and overrides counting. A value at or above the modulus is stored as `load_val` mod the modulus.
- R5: Counting up from modulus−1 gives 0. Any other value steps up by one.
- R6: Counting down from 0 gives modulus−1. Any other value steps down by one.
- R7: `DIR_MODE` selects the direction. `DIR_UP` always increments and `DIR_DOWN` always decrements, and in both modes `dir_up` is ignored. In `DIR_PORT`, `dir_up`=1 counts up and `dir_up`=0 counts down.
- R8: With `clk_en` high, no command and `cnt_en` low, the count holds.
- R9: With `clk_en` low, the count holds even when clear, set, load and count enable are all high.
- R10: The count never reaches the modulus.
- R11: When `WIDTH` is above 31, the modulus is not used and the counter wraps at 2^WIDTH. In that case `set_en` has no effect and a loaded value is stored without reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Gates every register action |
| cnt_en | input | 1 | Gates stepping only |
| clr_en | input | 1 | Synchronous clear to zero |
| set_en | input | 1 | Synchronous load of the preset constant |
| load_en | input | 1 | Synchronous load of `load_val` |
| load_val | input | WIDTH | Value to load |
| dir_up | input | 1 | 1 = up, 0 = down (port direction mode only) |
| count | output | WIDTH | Current count |

## Verification
The bench builds three copies side by side. The first is 8 bits wide with modulus 200, preset 5 and port direction, which exercises both wrap points, the priority chain and the fold of loads of 200 and above. The second is 4 bits wide, modulus 10, preset 7 and fixed down, which shows that the direction input is ignored and covers a modulus close to 2^WIDTH. The third is 33 bits wide with a modulus requested, which covers the natural wrap at 2^33, the ignored preset and a load that is not reduced.

// File: rtl/ctr_pkg.sv
// Shared definitions for the modulo counter.
// Assumes: nothing beyond IEEE 1800-2017.
package ctr_pkg;
    typedef enum logic [1:0] {
        DIR_UP   = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_PORT = 2'd2
    } dir_mode_e;
endpackage

// File: rtl/ctr_step.sv
// Next stepped value of the counter in either direction, wrapping
// between 0 and TOP_VAL. Purely combinational.
// Assumes: TOP_VAL is the largest legal count (modulus - 1).
module ctr_step #(
    parameter int unsigned       WIDTH   = 8,
    parameter logic [WIDTH-1:0]  TOP_VAL = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             go_up,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    // pick successor or predecessor with wrap at both ends
    always_comb begin
        if (go_up) begin
            nxt = (cur == TOP_VAL) ? ZERO : cur + ONE;
        end else begin
            nxt = (cur == ZERO) ? TOP_VAL : cur - ONE;
        end
    end
endmodule

// File: rtl/ctr_load_fold.sv
// Reduces a loaded value into the legal count range.
// Assumes: when MOD_ON is set, WIDTH <= 31 and MODULUS >= 1.
module ctr_load_fold #(
    parameter int unsigned WIDTH   = 8,
    parameter bit          MOD_ON  = 1'b1,
    parameter int unsigned MODULUS = 256
) (
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] folded
);
    generate
        if (MOD_ON) begin : g_fold
            logic [31:0] wide_raw;
            logic [31:0] wide_rem;
            // widen, take remainder against the modulus, narrow back
            always_comb begin
                wide_raw = 32'(raw);
                wide_rem = wide_raw % MODULUS;
                folded   = WIDTH'(wide_rem);
            end
        end else begin : g_pass
            // natural wrap: every vector is already legal
            always_comb folded = raw;
        end
    endgenerate
endmodule

// File: rtl/ctr_state_reg.sv
// Count register with synchronous reset and the priority chain
// clear > set > load > step, all gated by the clock enable.
// Assumes: load_val and step_val are already in range.
module ctr_state_reg #(
    parameter int unsigned      WIDTH      = 8,
    parameter bit               SET_ACTIVE = 1'b1,
    parameter logic [WIDTH-1:0] SET_VAL    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             clr_req,
    input  logic             set_req,
    input  logic             load_req,
    input  logic             step_req,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] step_val,
    output logic [WIDTH-1:0] count_q
);
    logic set_eff;

    // preset command only exists when the width allows it
    always_comb set_eff = SET_ACTIVE && set_req;

    // update the count by priority when the clock enable is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clk_en) begin
            if (clr_req) begin
                count_q <= '0;
            end else if (set_eff) begin
                count_q <= SET_VAL;
            end else if (load_req) begin
                count_q <= load_val;
            end else if (step_req) begin
                count_q <= step_val;
            end
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0));

    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && clr_req) |=> (count_q == '0));

    assert_hold_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !clr_req && !set_eff && !load_req && !step_req) |=> $stable(count_q));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(count_q));

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !clr_req && !set_eff && load_req) |=> (count_q == $past(load_val)));

    generate
        if (SET_ACTIVE) begin : g_set_chk
            assert_set_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && !clr_req && set_req) |=> (count_q == SET_VAL));
        end
    endgenerate
endmodule

// File: rtl/modcount_top.sv
// Modulo up/down counter. Width, modulus, preset and direction mode
// are parameters. Modulus and preset apply only up to 31 bits; wider
// counters wrap at 2^WIDTH and ignore set_en.
// Assumes: 2 <= MODULUS <= 2^WIDTH and SET_VALUE < MODULUS when used.
module modcount_top #(
    parameter int unsigned        WIDTH     = 8,
    parameter bit                 USE_MOD   = 1'b1,
    parameter int unsigned        MODULUS   = 200,
    parameter int unsigned        SET_VALUE = 5,
    parameter ctr_pkg::dir_mode_e DIR_MODE  = ctr_pkg::DIR_PORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cnt_en,
    input  logic             clr_en,
    input  logic             set_en,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count
);
    localparam bit               NARROW  = (WIDTH <= 31);
    localparam bit               MOD_ON  = USE_MOD && NARROW;
    localparam bit               SET_ON  = NARROW;
    localparam logic [WIDTH-1:0] TOP_VAL = MOD_ON ? WIDTH'(MODULUS - 1) : {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] SET_VEC = WIDTH'(SET_VALUE);

    logic             up_sel;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] fold_val;
    logic [WIDTH-1:0] count_q;

    generate
        if (DIR_MODE == ctr_pkg::DIR_UP) begin : g_dir_up
            // fixed increment
            always_comb up_sel = 1'b1;
        end else if (DIR_MODE == ctr_pkg::DIR_DOWN) begin : g_dir_dn
            // fixed decrement
            always_comb up_sel = 1'b0;
        end else begin : g_dir_port
            // direction follows the input pin
            always_comb up_sel = dir_up;
        end
    endgenerate

    ctr_step #(
        .WIDTH   (WIDTH),
        .TOP_VAL (TOP_VAL)
    ) u_step (
        .cur   (count_q),
        .go_up (up_sel),
        .nxt   (step_val)
    );

    ctr_load_fold #(
        .WIDTH   (WIDTH),
        .MOD_ON  (MOD_ON),
        .MODULUS (MODULUS)
    ) u_fold (
        .raw    (load_val),
        .folded (fold_val)
    );

    ctr_state_reg #(
        .WIDTH      (WIDTH),
        .SET_ACTIVE (SET_ON),
        .SET_VAL    (SET_VEC)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .clr_req  (clr_en),
        .set_req  (set_en),
        .load_req (load_en),
        .step_req (cnt_en),
        .load_val (fold_val),
        .step_val (step_val),
        .count_q  (count_q)
    );

    // drive the output straight from the register
    always_comb count = count_q;

    assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP_VAL);

    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !clr_en && !(set_en && SET_ON) && !load_en && cnt_en && up_sel
         && count == TOP_VAL) |=> (count == '0));

    assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !clr_en && !(set_en && SET_ON) && !load_en && cnt_en && !up_sel
         && count == '0) |=> (count == TOP_VAL));

    generate
        if (!NARROW) begin : g_wide_chk
            assert_wide_raw_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && !clr_en && load_en) |=> (count == $past(load_val)));
        end
    endgenerate
endmodule

// File: tb/modcount_top_bench.sv
module modcount_top_bench;
    logic        clk = 1'b0;
    logic        rst_n, clk_en, cnt_en, clr_en, set_en, load_en, dir_up;
    logic [7:0]  ld_a;
    logic [3:0]  ld_b;
    logic [32:0] ld_c;
    logic [7:0]  cnt_a;
    logic [3:0]  cnt_b;
    logic [32:0] cnt_c;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    modcount_top #(.WIDTH(8), .USE_MOD(1'b1), .MODULUS(200), .SET_VALUE(5),
                   .DIR_MODE(ctr_pkg::DIR_PORT)) u_modcount_top (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cnt_en(cnt_en), .clr_en(clr_en),
        .set_en(set_en), .load_en(load_en), .load_val(ld_a), .dir_up(dir_up), .count(cnt_a));

    modcount_top #(.WIDTH(4), .USE_MOD(1'b1), .MODULUS(10), .SET_VALUE(7),
                   .DIR_MODE(ctr_pkg::DIR_DOWN)) u_modcount_top_dn (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cnt_en(cnt_en), .clr_en(clr_en),
        .set_en(set_en), .load_en(load_en), .load_val(ld_b), .dir_up(dir_up), .count(cnt_b));

    modcount_top #(.WIDTH(33), .USE_MOD(1'b1), .MODULUS(100), .SET_VALUE(9),
                   .DIR_MODE(ctr_pkg::DIR_UP)) u_modcount_top_wide (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cnt_en(cnt_en), .clr_en(clr_en),
        .set_en(set_en), .load_en(load_en), .load_val(ld_c), .dir_up(dir_up), .count(cnt_c));

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock edge, then sample just after it
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle();
        clk_en = 1'b1; cnt_en = 1'b0; clr_en = 1'b0; set_en = 1'b0; load_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); dir_up = 1'b1; ld_a = '0; ld_b = '0; ld_c = '0;
        tick(2);
        check("R1", "a after reset", cnt_a, 0);
        check("R1", "b after reset", cnt_b, 0);
        check("R1", "c after reset", cnt_c, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        idle(); cnt_en = 1'b1; dir_up = 1'b1;
        tick(3);
        check("R7", "a port up x3", cnt_a, 3);
        check("R6", "b fixed down from 0 x3", cnt_b, 7);
        check("R7", "c fixed up x3", cnt_c, 3);
        dir_up = 1'b0;
        tick(1);
        check("R7", "a port down", cnt_a, 2);
        check("R7", "b ignores dir_up", cnt_b, 6);
        check("R7", "c ignores dir_up", cnt_c, 4);
    endtask

    task automatic t_hold();
        idle(); dir_up = 1'b1;
        tick(3);
        check("R8", "a held", cnt_a, 2);
        check("R8", "b held", cnt_b, 6);
        check("R8", "c held", cnt_c, 4);
    endtask

    task automatic t_freeze();
        clk_en = 1'b0; cnt_en = 1'b1; clr_en = 1'b1; set_en = 1'b1; load_en = 1'b1;
        ld_a = 8'd77; ld_b = 4'd1; ld_c = 33'd55;
        tick(3);
        check("R9", "a frozen", cnt_a, 2);
        check("R9", "b frozen", cnt_b, 6);
        check("R9", "c frozen", cnt_c, 4);
        idle();
    endtask

    task automatic t_load();
        idle(); load_en = 1'b1; cnt_en = 1'b1;
        ld_a = 8'd123; ld_b = 4'd13; ld_c = 33'd150;
        tick(1);
        check("R4", "a load beats count", cnt_a, 123);
        check("R4", "b load 13 folds to 3", cnt_b, 3);
        check("R11", "c load 150 not reduced", cnt_c, 150);
        ld_a = 8'd250;
        tick(1);
        check("R4", "a load 250 folds to 50", cnt_a, 50);
        idle();
    endtask

    task automatic t_wrap();
        idle(); load_en = 1'b1; ld_a = 8'd198; ld_b = 4'd1; ld_c = 33'h1_FFFF_FFFF;
        tick(1);
        load_en = 1'b0; cnt_en = 1'b1; dir_up = 1'b1;
        tick(1);
        check("R5", "a 198 up", cnt_a, 199);
        check("R6", "b 1 down", cnt_b, 0);
        check("R11", "c all ones up wraps", cnt_c, 0);
        tick(1);
        check("R5", "a 199 up wraps", cnt_a, 0);
        check("R6", "b 0 down wraps", cnt_b, 9);
        dir_up = 1'b0;
        tick(1);
        check("R6", "a 0 down wraps", cnt_a, 199);
        idle();
    endtask

    task automatic t_priority();
        idle(); clr_en = 1'b1; set_en = 1'b1; load_en = 1'b1; cnt_en = 1'b1;
        ld_a = 8'd40; ld_b = 4'd2; ld_c = 33'd60;
        tick(1);
        check("R2", "a clear wins", cnt_a, 0);
        check("R2", "b clear wins", cnt_b, 0);
        check("R2", "c clear wins", cnt_c, 0);
        clr_en = 1'b0;
        tick(1);
        check("R3", "a set wins", cnt_a, 5);
        check("R3", "b set wins", cnt_b, 7);
        check("R11", "c set ignored, load taken", cnt_c, 60);
        idle();
    endtask

    task automatic t_long_run();
        int model;
        idle(); clr_en = 1'b1;
        tick(1);
        clr_en = 1'b0; cnt_en = 1'b1; dir_up = 1'b1; model = 0;
        for (int i = 0; i < 450; i++) begin
            tick(1);
            model = (model + 1) % 200;
            check("R10", "a long up run", cnt_a, model);
            if (cnt_a >= 8'd200) check("R10", "a below modulus", cnt_a, 199);
        end
        idle();
    endtask

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_freeze();
        t_load();
        t_wrap();
        t_priority();
        t_long_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule